// File: doc/BRIEF.md
# Time-Shared Address/Data Bus Cycle Controller

This block performs one memory or I/O transfer at a time on a 16-bit bus whose lines carry first the address and then the data. Four more lines carry the top address bits and then status. A requester presents a 20-bit address, a direction, a memory/I/O select, a byte/word size, a two-bit segment code and write data. The controller then runs a four-state bus cycle: T1 address, T2 turnaround, and T3/T4 data. It generates the address-latch strobe, the read and write strobes, the direction line, the memory/I/O select, and the active-low upper-lane enable.

Byte lanes follow address bit 0 and the upper-lane enable. A word at an odd address cannot use both lanes at once. It is split into two complete bus cycles: first the odd address on the upper lane, then the next even address on the lower lane. Read data returns to the requester realigned, with a single-cycle done pulse after the last bus cycle.

States: `ST_IDLE` (ready for a request), `ST_T1` (address phase), `ST_T2` (turnaround, strobe starts), `ST_T3` (data, read sampled at its end) and `ST_T4` (data hold, strobe off). Transitions:
- IDLE→T1 on an accepted request.
- T1→T2, T2→T3 and T3→T4 always.
- T4→T1 after the first half of a split word.
- T4→IDLE otherwise.

Top module: `mux_bus_cycle_ctrl`

## Requirements
- R1: After reset and whenever idle: `req_ready`=1, `rd_n`=`wr_n`=`bhe_n`=1, `ad_oe`=0, `ale`=0, `rsp_done`=0, `m_io`=0, `dt_r`=0.
- R2: A request accepted on a clock edge with `req_ready`=1 puts the next cycle in T1. During T1, `ale`=1, `ad_oe`=1, `ad_out` = address bits 15..0 and `as_out` = address bits 19..16. `ale` is 0 in every other state.
- R3: In T2, T3 and T4, `as_out` is the status nibble {bit3 = 0, bit2 = 0, bits1..0 = segment code}.
- R4: During T1–T4, `m_io` equals the request's memory flag (1 memory, 0 I/O), `dt_r` is 1 for a write and 0 for a read, and `bhe_n` holds the value for the current cycle.
- R5: For a read, `rd_n` is 0 in T2 and T3 only, and `ad_oe` is 0 from T2 through T4.
- R6: For a write, `wr_n` is 0 in T2 and T3 only, and `ad_oe`=1 with stable lane data on `ad_out` from T2 through T4.
- R7: Lane select: an even word uses `bhe_n`=0 with address bit 0 = 0. An even byte uses `bhe_n`=1 with bit 0 = 0. An odd byte uses `bhe_n`=0 with bit 0 = 1.
- R8: Write lanes: an even byte drives `wdata[7:0]` on `ad_out[7:0]` and zero on `[15:8]`. An odd byte drives `wdata[7:0]` on `ad_out[15:8]` and zero on `[7:0]`. An even word drives all 16 bits.
- R9: A word at an odd address runs two cycles. The first uses the odd address, `bhe_n`=0, and `wdata[7:0]` on the upper lane. The second uses address+1 (wrapping modulo 2^20), `bhe_n`=1, and `wdata[15:8]` on the lower lane.
- R10: Read data is sampled at the end of T3. `rsp_rdata` is the whole bus for an even word. For a byte it is {8'h00, addressed lane}. For an odd word it is {second cycle `ad_in[7:0]`, first cycle `ad_in[15:8]`}.
- R11: `rsp_done` is a one-cycle pulse in the cycle after the final T4 only, never after the first half of a split. `req_ready` is 0 from T1 through the final T4.
- R12: `req_valid` while `req_ready`=0 is ignored: no extra bus cycle and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 20 | Byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_word | input | 1 | 1 word, 0 byte |
| req_seg | input | 2 | Segment code reported in status |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| req_ready | output | 1 | Idle, request will be accepted |
| rsp_done | output | 1 | Transfer complete pulse |
| rsp_rdata | output | 16 | Realigned read data |
| ad_out | output | 16 | Address/data lines, driven value |
| ad_oe | output | 1 | Address/data lines driven |
| ad_in | input | 16 | Address/data lines, sampled value |
| as_out | output | 4 | Address 19..16 in T1, status later |
| ale | output | 1 | Address latch strobe |
| bhe_n | output | 1 | Upper-lane enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | 1 memory, 0 I/O |
| dt_r | output | 1 | 1 transmit, 0 receive |

## Verification
A wrong state register shows at the pins at once. A missing or repeated T-state moves the read or write strobe by a whole cycle in that same bus cycle. A skipped split phase leaves one `ale` pulse where two were expected, and `rsp_done` then arrives four cycles early. A wrong lane descriptor shows in T1 as a bad `bhe_n` or address bit 0, or in T2 as write data on the wrong byte lane. On reads, a wrong descriptor surfaces only at the done pulse, as a misplaced byte in `rsp_rdata`.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4
    } bus_state_e;

    typedef enum logic [1:0] {
        LANE_LO,
        LANE_HI,
        LANE_BOTH
    } lane_e;

    // Per-bus-cycle plan: lane use, which request byte it carries, address step.
    typedef struct packed {
        logic  bhe_n;
        lane_e lane;
        logic  upper_byte;
        logic  addr_inc;
    } cyc_desc_t;

endpackage

// File: rtl/mbc_cycle_plan.sv
module mbc_cycle_plan
    import mbc_pkg::*;
(
    input  logic      addr_lsb,
    input  logic      is_word,
    output cyc_desc_t first_cyc,
    output cyc_desc_t second_cyc,
    output logic      split
);
    always_comb begin
        split                 = is_word && addr_lsb;
        first_cyc             = '0;
        second_cyc            = '0;
        second_cyc.bhe_n      = 1'b1;
        second_cyc.lane       = LANE_LO;
        second_cyc.upper_byte = 1'b1;
        second_cyc.addr_inc   = 1'b1;
        unique case ({is_word, addr_lsb})
            2'b10: begin
                first_cyc.bhe_n = 1'b0;
                first_cyc.lane  = LANE_BOTH;
            end
            2'b00: begin
                first_cyc.bhe_n = 1'b1;
                first_cyc.lane  = LANE_LO;
            end
            2'b01, 2'b11: begin
                first_cyc.bhe_n = 1'b0;
                first_cyc.lane  = LANE_HI;
            end
            default: first_cyc = '0;
        endcase
    end
endmodule

// File: rtl/mbc_lane_steer.sv
module mbc_lane_steer
    import mbc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  cyc_desc_t         desc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W/2-1:0] rd_byte
);
    localparam int LANE_W = DATA_W / 2;

    logic [LANE_W-1:0] src_byte;

    always_comb begin
        src_byte = desc.upper_byte ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];
        unique case (desc.lane)
            LANE_LO:   bus_wdata = {{LANE_W{1'b0}}, src_byte};
            LANE_HI:   bus_wdata = {src_byte, {LANE_W{1'b0}}};
            default:   bus_wdata = wdata;
        endcase
        rd_byte = (desc.lane == LANE_HI) ? bus_rdata[DATA_W-1:LANE_W]
                                         : bus_rdata[LANE_W-1:0];
    end
endmodule

// File: rtl/mbc_read_gather.sv
module mbc_read_gather
    import mbc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  cyc_desc_t           desc,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic [DATA_W/2-1:0] rd_byte,
    output logic [DATA_W-1:0]   gathered
);
    localparam int LANE_W = DATA_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gathered <= '0;
        end else if (capture) begin
            if (desc.lane == LANE_BOTH) begin
                gathered <= bus_rdata;
            end else if (desc.upper_byte) begin
                gathered[DATA_W-1:LANE_W] <= rd_byte;
            end else begin
                gathered <= {{LANE_W{1'b0}}, rd_byte};
            end
        end
    end
endmodule

// File: rtl/mux_bus_cycle_ctrl.sv
module mux_bus_cycle_ctrl
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    input  logic                     req_mem,
    input  logic                     req_word,
    input  logic [SEG_W-1:0]         req_seg,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic                     ale,
    output logic                     bhe_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     m_io,
    output logic                     dt_r
);
    localparam int STAT_W = ADDR_W - DATA_W;
    localparam int LANE_W = DATA_W / 2;

    bus_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [SEG_W-1:0]  seg_q;
    logic              wr_q, mem_q, split_q, phase_q, done_q;
    cyc_desc_t         desc1_q, desc2_q, cur_desc;
    cyc_desc_t         plan1, plan2;
    logic              plan_split;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] lane_wdata;
    logic [LANE_W-1:0] lane_rbyte;
    logic [STAT_W-1:0] status_nib;
    logic              accept, last_t4;

    mbc_cycle_plan u_plan (
        .addr_lsb   (req_addr[0]),
        .is_word    (req_word),
        .first_cyc  (plan1),
        .second_cyc (plan2),
        .split      (plan_split)
    );

    assign cur_desc = phase_q ? desc2_q : desc1_q;
    assign cur_addr = addr_q + ADDR_W'(cur_desc.addr_inc);

    mbc_lane_steer #(.DATA_W(DATA_W)) u_steer (
        .desc      (cur_desc),
        .wdata     (wdata_q),
        .bus_wdata (lane_wdata),
        .bus_rdata (ad_in),
        .rd_byte   (lane_rbyte)
    );

    mbc_read_gather #(.DATA_W(DATA_W)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (state_q == ST_T3 && !wr_q),
        .desc      (cur_desc),
        .bus_rdata (ad_in),
        .rd_byte   (lane_rbyte),
        .gathered  (rsp_rdata)
    );

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign last_t4 = (state_q == ST_T4) && !(split_q && !phase_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   state_d = ST_T4;
            ST_T4:   state_d = (split_q && !phase_q) ? ST_T1 : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request latch, split phase and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            seg_q   <= '0;
            wr_q    <= 1'b0;
            mem_q   <= 1'b0;
            split_q <= 1'b0;
            phase_q <= 1'b0;
            desc1_q <= '0;
            desc2_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last_t4;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                seg_q   <= req_seg;
                wr_q    <= req_write;
                mem_q   <= req_mem;
                split_q <= plan_split;
                phase_q <= 1'b0;
                desc1_q <= plan1;
                desc2_q <= plan2;
            end else if (state_q == ST_T4 && split_q && !phase_q) begin
                phase_q <= 1'b1;
            end
        end
    end

    always_comb begin
        status_nib            = '0;
        status_nib[SEG_W-1:0] = seg_q;
    end

    // Pin outputs per state
    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        as_out = '0;
        ale    = 1'b0;
        bhe_n  = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        m_io   = 1'b0;
        dt_r   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = cur_addr[DATA_W-1:0];
                as_out = cur_addr[ADDR_W-1:DATA_W];
                bhe_n  = cur_desc.bhe_n;
                m_io   = mem_q;
                dt_r   = wr_q;
            end
            ST_T2, ST_T3: begin
                as_out = status_nib;
                bhe_n  = cur_desc.bhe_n;
                m_io   = mem_q;
                dt_r   = wr_q;
                ad_oe  = wr_q;
                ad_out = wr_q ? lane_wdata : '0;
                rd_n   = wr_q;
                wr_n   = !wr_q;
            end
            ST_T4: begin
                as_out = status_nib;
                bhe_n  = cur_desc.bhe_n;
                m_io   = mem_q;
                dt_r   = wr_q;
                ad_oe  = wr_q;
                ad_out = wr_q ? lane_wdata : '0;
            end
            default: begin
            end
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_done  = done_q;

    // R5/R6: never both strobes
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R5: bus released while reading
    p_rd_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R6: write data held while the write strobe stays low
    p_wr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> $stable(ad_out));
    // R2: address strobe lasts one cycle and is followed by a strobe
    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && (!rd_n || !wr_n)));
    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R11: not ready while a bus cycle is running
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !req_ready);
    // R3: S6 position low after address phase
    p_s6_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !as_out[STAT_W-1]);
endmodule

// File: tb/tb_mux_bus_cycle_ctrl.sv
module tb_mux_bus_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0, req_mem = 1'b0, req_word = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, ad_oe, ale, bhe_n, rd_n, wr_n, m_io, dt_r;
    logic [15:0] rsp_rdata, ad_out;
    logic [15:0] ad_in = '0;
    logic [3:0]  as_out;

    always #5 clk = ~clk;

    mux_bus_cycle_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_mem(req_mem), .req_word(req_word),
        .req_seg(req_seg), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .as_out(as_out), .ale(ale),
        .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r)
    );

    typedef struct {
        logic [19:0] addr;
        logic        bhe_n;
        logic        wr;
        logic        mem;
        logic [1:0]  seg;
        logic [15:0] wd;
        logic [15:0] rbus;
    } cyc_t;

    typedef struct {
        logic        rd;
        logic [15:0] data;
    } rsp_t;

    cyc_t cyc_q[$];
    rsp_t rsp_q[$];
    int   checks = 0, errors = 0;
    int   cycle = 0, t4_cycle = -10, done_seen = 0, issued = 0;

    always @(posedge clk) cycle <= cycle + 1;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [19:0] a, input logic wr, input logic mem,
                          input logic word, input logic [1:0] seg, input logic [15:0] wd,
                          input logic [15:0] b0, input logic [15:0] b1, input bit poke);
        cyc_t c1, c2;
        rsp_t r;
        c1.addr = a; c1.wr = wr; c1.mem = mem; c1.seg = seg; c1.rbus = b0;
        c2 = c1;
        r.rd = !wr;
        if (word && !a[0]) begin
            c1.bhe_n = 1'b0; c1.wd = wd; r.data = b0;
            cyc_q.push_back(c1);
        end else if (!word && !a[0]) begin
            c1.bhe_n = 1'b1; c1.wd = {8'h00, wd[7:0]}; r.data = {8'h00, b0[7:0]};
            cyc_q.push_back(c1);
        end else if (!word) begin
            c1.bhe_n = 1'b0; c1.wd = {wd[7:0], 8'h00}; r.data = {8'h00, b0[15:8]};
            cyc_q.push_back(c1);
        end else begin
            c1.bhe_n = 1'b0; c1.wd = {wd[7:0], 8'h00};
            c2.addr = a + 20'd1; c2.bhe_n = 1'b1; c2.wd = {8'h00, wd[15:8]}; c2.rbus = b1;
            r.data = {b1[7:0], b0[15:8]};
            cyc_q.push_back(c1);
            cyc_q.push_back(c2);
        end
        rsp_q.push_back(r);
        issued++;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_mem = mem;
        req_word = word; req_seg = seg; req_wdata = wd;
        @(negedge clk);
        if (poke) begin
            // R12: request held while busy must be ignored
            req_addr = 20'h0BEEF; req_word = 1'b0;
            repeat (3) @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // Bus monitor: consumes expected bus cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ale) begin
                if (cyc_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected bus cycle", 32'(ad_out), 32'h0);
                end else begin
                    cyc_t c;
                    c = cyc_q.pop_front();
                    chk(ad_oe && ad_out == c.addr[15:0], "R2 T1 address low", 32'(ad_out), 32'(c.addr[15:0]));
                    chk(as_out == c.addr[19:16], "R2 T1 address high", 32'(as_out), 32'(c.addr[19:16]));
                    chk(bhe_n == c.bhe_n, "R7/R9 bhe_n", 32'(bhe_n), 32'(c.bhe_n));
                    chk(m_io == c.mem && dt_r == c.wr, "R4 m_io/dt_r", {m_io, dt_r}, {c.mem, c.wr});
                    chk(rd_n && wr_n && !req_ready && !rsp_done, "R11 T1 strobes idle/busy",
                        {rd_n, wr_n, req_ready, rsp_done}, 32'b1100);
                    ad_in = c.wr ? 16'h0000 : c.rbus;
                    for (int t = 2; t <= 4; t++) begin
                        @(negedge clk);
                        chk(!ale && as_out == {2'b00, c.seg}, "R3 status nibble", {ale, as_out}, {1'b0, 2'b00, c.seg});
                        chk(m_io == c.mem && dt_r == c.wr && bhe_n == c.bhe_n, "R4 held controls",
                            {m_io, dt_r, bhe_n}, {c.mem, c.wr, c.bhe_n});
                        chk(rd_n == (c.wr || t == 4), "R5 read strobe", 32'(rd_n), 32'(c.wr || t == 4));
                        chk(wr_n == (!c.wr || t == 4), "R6 write strobe", 32'(wr_n), 32'(!c.wr || t == 4));
                        chk(ad_oe == c.wr, "R5/R6 bus drive", 32'(ad_oe), 32'(c.wr));
                        if (c.wr) chk(ad_out == c.wd, "R8/R9 write lanes", 32'(ad_out), 32'(c.wd));
                        chk(!req_ready, "R11 busy", 32'(req_ready), 32'h0);
                    end
                    t4_cycle = cycle;
                    ad_in = 16'h0000;
                end
            end
        end
    end

    // Response monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_done) begin
                done_seen++;
                chk(cycle == t4_cycle + 1 && cyc_q.size() == 0 || rsp_q.size() > 1,
                    "R11 done after final T4", 32'(cycle), 32'(t4_cycle + 1));
                if (rsp_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected done", 32'h1, 32'h0);
                end else begin
                    rsp_t r;
                    r = rsp_q.pop_front();
                    if (r.rd) chk(rsp_rdata == r.data, "R10 read data", 32'(rsp_rdata), 32'(r.data));
                end
            end
        end
    end

    bit finished = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && rd_n && wr_n && bhe_n && !ad_oe && !ale && !rsp_done && !m_io && !dt_r,
            "R1 reset idle", {req_ready, rd_n, wr_n, bhe_n, ad_oe, ale, rsp_done, m_io, dt_r},
            9'b111100000);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 even word read, memory
        do_req(20'h12344, 1'b0, 1'b1, 1'b1, 2'd3, 16'h0000, 16'hBEEF, 16'h0, 1'b0);
        // R8 even word write, I/O
        do_req(20'h00F02, 1'b1, 1'b0, 1'b1, 2'd1, 16'hA55A, 16'h0, 16'h0, 1'b0);
        // R10 even byte read
        do_req(20'hABCD0, 1'b0, 1'b1, 1'b0, 2'd2, 16'h0000, 16'h7733, 16'h0, 1'b0);
        // R10 odd byte read
        do_req(20'h54321, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h9A44, 16'h0, 1'b0);
        // R8 even and odd byte writes
        do_req(20'h00010, 1'b1, 1'b1, 1'b0, 2'd1, 16'h12C3, 16'h0, 16'h0, 1'b0);
        do_req(20'h00011, 1'b1, 1'b1, 1'b0, 2'd2, 16'h34D5, 16'h0, 16'h0, 1'b0);
        // R9/R10 odd word read, split
        do_req(20'h10001, 1'b0, 1'b1, 1'b1, 2'd3, 16'h0000, 16'h5611, 16'h2278, 1'b0);
        // R9 odd word write, split
        do_req(20'h20003, 1'b1, 1'b1, 1'b1, 2'd0, 16'hCAFE, 16'h0, 16'h0, 1'b0);
        // R9 split wrapping past the top address
        do_req(20'hFFFFF, 1'b0, 1'b1, 1'b1, 2'd1, 16'h0000, 16'hC300, 16'h00D4, 1'b0);
        // R12 request held while busy
        do_req(20'h3A5A6, 1'b1, 1'b0, 1'b1, 2'd2, 16'h0F1E, 16'h0, 16'h0, 1'b1);
        do_req(20'h00002, 1'b0, 1'b1, 1'b1, 2'd0, 16'h0000, 16'h1357, 16'h0, 1'b0);
        repeat (12) @(negedge clk);
        chk(cyc_q.size() == 0 && rsp_q.size() == 0, "R12 all expected items consumed",
            32'(cyc_q.size() + rsp_q.size()), 32'h0);
        chk(done_seen == issued, "R11/R12 done count", 32'(done_seen), 32'(issued));
        chk(req_ready && !ale && rd_n && wr_n && !ad_oe && !rsp_done, "R1 idle after traffic",
            {req_ready, ale, rd_n, wr_n, ad_oe, rsp_done}, 6'b101100);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule